// File: doc/BRIEF.md
# Serial LED Status Serializer

This block gathers nineteen hub status flags into a 24-bit frame and sends it out, at fixed intervals, as a short train of clock pulses with a matching data line. An external serial-in shift register clocks in the data line on each rising clock edge and holds the result on its parallel outputs to drive LEDs. Between trains the clock line stays low, so the external register keeps the last frame on display.

The status inputs are eight port partition flags, eight port receive-activity flags, a 10 Mb/s collision flag, a 100 Mb/s collision flag and a memory self-test failure flag. The frame carries the flags of ports 3 to 7 twice, so that each byte of a byte-wide external register chain has a fixed meaning. The block samples every flag once, on the cycle a train begins, and sends that copy for the whole train.

The block runs on a 50 MHz system clock. Each output clock period is two half periods of `HALF_CYCLES` system clocks. A train begins every `FRAME_CYCLES` system clocks. With the defaults this gives a 160 ns pulse period, a 3.84 us train and a 42 ms repeat interval. A test can set `FRAME_CYCLES` much lower.

Top module: `led_status_serializer`

## Requirements
- R1: Every pulse train has exactly 24 rising edges on `led_clk`.
- R2: Within a train each `led_clk` high phase lasts `HALF_CYCLES` system clocks, and each low phase between two pulses of the same train also lasts `HALF_CYCLES` system clocks. The default of 4 gives a 160 ns period at 50 MHz.
- R3: Consecutive trains begin exactly `FRAME_CYCLES` system clocks apart. The default of 2,100,000 gives 42 ms.
- R4: The n-th rising edge of a train, counted from 0, carries frame bit n, so bit 0 goes first and bit 23 goes last.
- R5: Frame bits 0 to 7 hold the partition flags of ports 0 to 7. Bit 8 holds the 10 Mb/s collision flag, bit 9 the 100 Mb/s collision flag and bit 10 the memory-test-fail flag. All of them are active high.
- R6: Frame bits 11 to 15 repeat the partition flags of ports 3 to 7 in that order. Bits 16 to 23 hold the receive-activity flags of ports 0 to 7.
- R7: `led_data` changes only on the cycle `led_clk` falls, or on the cycle a train begins. It is stable for at least `HALF_CYCLES` system clocks (80 ns by default) before each rising edge, and it does not change while `led_clk` is high.
- R8: The frame is sampled on the cycle a train begins. Any change to the status inputs after that cycle has no effect on the bits of that train.
- R9: After reset and between trains, both `led_clk` and `led_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| part_flags | input | 8 | Partition flag per port, bit n is port n |
| act_flags | input | 8 | Receive-activity flag per port, bit n is port n |
| col_10m | input | 1 | 10 Mb/s domain collision flag |
| col_100m | input | 1 | 100 Mb/s domain collision flag |
| mem_fail | input | 1 | Memory self-test failure flag |
| led_clk | output | 1 | Gated burst clock to the external shift register |
| led_data | output | 1 | Serial frame data, active high |

## Verification
The checker's properties assume that a new train never starts while the previous train is still being sent. This holds only if `FRAME_CYCLES` is longer than 24 pulse periods. The bench keeps to this by using a 300-cycle frame against a 192-cycle train. The status inputs may change at any time, and nothing in the checker depends on when they change. The bench changes them once in mid-train on purpose, and otherwise changes them only in the idle gap. This way each captured frame can be compared with one known input pattern. The sweep covers all-zero, a walking one over each of the nineteen flags, all-ones and two mixed patterns.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int NUM_PORTS  = 8;
  localparam int FRAME_BITS = 24;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int COL10_POS  = 8;
  localparam int COL100_POS = 9;
  localparam int MFAIL_POS  = 10;
  localparam int REPEAT_LO  = 3;
  localparam int ACT_BASE   = 16;

  typedef logic [FRAME_BITS-1:0] led_frame_t;
  typedef logic [NUM_PORTS-1:0]  port_flags_t;
endpackage

// File: rtl/led_frame_timer.sv
module led_frame_timer #(
  parameter int FRAME_CYCLES = 2_100_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CNT_LAST);
      if (cnt == CNT_LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/led_status_map.sv
module led_status_map
  import led_ser_pkg::*;
(
  input  port_flags_t part_flags,
  input  port_flags_t act_flags,
  input  logic        col_10m,
  input  logic        col_100m,
  input  logic        mem_fail,
  output led_frame_t  frame
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign frame[p]            = part_flags[p];
    assign frame[ACT_BASE + p] = act_flags[p];
  end

  for (genvar r = REPEAT_LO; r < NUM_PORTS; r++) begin : g_repeat
    assign frame[MFAIL_POS + 1 + r - REPEAT_LO] = part_flags[r];
  end

  assign frame[COL10_POS]  = col_10m;
  assign frame[COL100_POS] = col_100m;
  assign frame[MFAIL_POS]  = mem_fail;
endmodule

// File: rtl/led_burst_shifter.sv
module led_burst_shifter
  import led_ser_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  led_frame_t       frame_in,
  output logic             led_clk,
  output logic             led_data,
  output logic             busy,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int PH_W = $clog2(2 * HALF_CYCLES);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(HALF_CYCLES - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  led_frame_t      snap;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      phase    <= '0;
      bit_idx  <= '0;
      busy     <= 1'b0;
      led_clk  <= 1'b0;
      led_data <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        snap     <= frame_in;
        bit_idx  <= '0;
        phase    <= '0;
        led_clk  <= 1'b0;
        led_data <= frame_in[0];
      end
    end else if (phase == PH_LAST) begin
      phase   <= '0;
      led_clk <= 1'b0;
      if (bit_idx == LAST_BIT) begin
        busy     <= 1'b0;
        bit_idx  <= '0;
        led_data <= 1'b0;
      end else begin
        bit_idx  <= bit_idx + 1'b1;
        led_data <= snap[bit_idx + 1'b1];
      end
    end else begin
      phase <= phase + 1'b1;
      if (phase == PH_RISE) led_clk <= 1'b1;
    end
  end
endmodule

// File: rtl/led_status_serializer.sv
module led_status_serializer
  import led_ser_pkg::*;
#(
  parameter int FRAME_CYCLES = 2_100_000,
  parameter int HALF_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] part_flags,
  input  logic [7:0] act_flags,
  input  logic       col_10m,
  input  logic       col_100m,
  input  logic       mem_fail,
  output logic       led_clk,
  output logic       led_data
);
  logic             frame_tick;
  logic             burst_active;
  logic [IDX_W-1:0] bit_idx;
  led_frame_t       status_frame;

  led_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (frame_tick)
  );

  led_status_map u_map (
    .part_flags (part_flags),
    .act_flags  (act_flags),
    .col_10m    (col_10m),
    .col_100m   (col_100m),
    .mem_fail   (mem_fail),
    .frame      (status_frame)
  );

  led_burst_shifter #(.HALF_CYCLES(HALF_CYCLES)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (frame_tick),
    .frame_in (status_frame),
    .led_clk  (led_clk),
    .led_data (led_data),
    .busy     (burst_active),
    .bit_idx  (bit_idx)
  );
endmodule

// File: rtl/led_status_serializer_chk.sv
module led_status_serializer_chk
  import led_ser_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             led_clk,
  input logic             led_data,
  input logic             frame_tick,
  input logic             burst_active,
  input logic [IDX_W-1:0] bit_idx
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (led_clk) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R2
  high_width_chk: assert property (@(posedge clk) disable iff (rst)
    led_clk |-> (hi_cnt < 16'(HALF_CYCLES)));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    led_clk |-> $stable(led_data));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_active |-> (!led_clk && !led_data));

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> !burst_active);

  // R1
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_idx < IDX_W'(FRAME_BITS));

  // R1
  train_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(burst_active) |-> ($past(bit_idx) == IDX_W'(FRAME_BITS - 1)));
endmodule

bind led_status_serializer led_status_serializer_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .led_clk      (led_clk),
  .led_data     (led_data),
  .frame_tick   (frame_tick),
  .burst_active (burst_active),
  .bit_idx      (bit_idx)
);

// File: tb/led_status_serializer_test.sv
`timescale 1ns/1ps
module led_status_serializer_test;
  localparam int CLK_PERIOD = 20;
  localparam int FRAME      = 300;
  localparam int HALF       = 4;
  localparam int NPAT       = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] part_flags = '0;
  logic [7:0] act_flags  = '0;
  logic col_10m = 1'b0, col_100m = 1'b0, mem_fail = 1'b0;
  logic led_clk, led_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_status_serializer #(.FRAME_CYCLES(FRAME), .HALF_CYCLES(HALF)) uut (
    .clk(clk), .rst(rst), .part_flags(part_flags), .act_flags(act_flags),
    .col_10m(col_10m), .col_100m(col_100m), .mem_fail(mem_fail),
    .led_clk(led_clk), .led_data(led_data)
  );

  // monitor state, sampled on the falling system clock edge
  int cyc = 0, high_run = 0, low_run = 0, dstab = 0;
  int pulses = 0, bursts = 0, burst_pulses = 0;
  int cur_start = 0, period = 0;
  int width_err = 0, gap_err = 0, setup_err = 0, hold_err = 0;
  bit in_burst = 0, have_start = 0;
  logic prev_clk = 1'b0, prev_data = 1'b0;
  logic [23:0] cap = '0, burst_cap = '0;
  logic idle_data = 1'b0, idle_clk = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_clk = 1'b0; prev_data = 1'b0; high_run = 0; low_run = 0; dstab = 0;
    end else begin
      cyc++;
      if (led_data == prev_data) dstab++; else dstab = 1;
      if (led_clk && !prev_clk) begin
        if (!in_burst) begin
          in_burst = 1; pulses = 0; cap = '0;
          if (have_start) period = cyc - cur_start;
          cur_start = cyc; have_start = 1;
        end else if (low_run != HALF) gap_err++;
        if (dstab < HALF + 1) setup_err++;
        if (pulses < 24) cap[pulses] = led_data;
        pulses++;
        high_run = 1;
      end else if (led_clk) begin
        high_run++;
        if (led_data != prev_data) hold_err++;
      end else if (prev_clk) begin
        if (high_run != HALF) width_err++;
        low_run = 1;
      end else begin
        low_run++;
        if (in_burst && low_run == 3 * HALF) begin
          in_burst = 0; burst_pulses = pulses; burst_cap = cap;
          idle_data = led_data; idle_clk = led_clk;
          bursts++;
        end
      end
      prev_clk = led_clk; prev_data = led_data;
    end
  end

  function automatic logic [18:0] vec_of(int p);
    if (p == 0)       return '0;
    else if (p <= 19) return 19'(1) << (p - 1);
    else if (p == 20) return '1;
    else if (p == 21) return 19'h55555;
    else              return 19'h2A5C3;
  endfunction

  // vec = {act[7:0], part[7:0], mem_fail, col_100m, col_10m}
  function automatic logic [23:0] exp_of(logic [18:0] v);
    logic [7:0] pa, ac;
    pa = v[10:3]; ac = v[18:11];
    return {ac, pa[7:3], v[2], v[1], v[0], pa};
  endfunction

  task automatic apply(logic [18:0] v);
    {act_flags, part_flags, mem_fail, col_100m, col_10m} = v;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d bursts", bursts, NPAT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(led_clk == 1'b0, "R9 reset clk", int'(led_clk), 0);
    check(led_data == 1'b0, "R9 reset data", int'(led_data), 0);
    rst = 1'b0;
    for (int p = 0; p < NPAT; p++) begin
      int target;
      logic [18:0] v;
      @(negedge clk);
      v = vec_of(p);
      apply(v);
      target = bursts + 1;
      if (p == NPAT - 1) begin
        // R8: flip every input after the train has begun
        wait (in_burst && pulses >= 3);
        @(negedge clk);
        apply(~v);
      end
      wait (bursts == target);
      check(burst_pulses == 24, "R1 pulse count", burst_pulses, 24);
      check(burst_cap == exp_of(v), (p == NPAT - 1) ? "R8 snapshot" :
            "R4 R5 R6 frame bits", int'(burst_cap), int'(exp_of(v)));
      check(width_err == 0 && gap_err == 0, "R2 pulse timing",
            width_err + gap_err, 0);
      check(setup_err == 0 && hold_err == 0, "R7 data setup/hold",
            setup_err + hold_err, 0);
      check(idle_clk == 1'b0 && idle_data == 1'b0, "R9 idle lines",
            int'({idle_clk, idle_data}), 0);
      if (bursts >= 2) check(period == FRAME, "R3 repeat interval", period, FRAME);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule